// File: doc/BRIEF.md
# Reply Reorder Buffer with Credit-Gated Issue

This block sits beside a master that sends pipelined requests to several slaves across a network. Those slaves can answer in any order. The block hands out a tag with every request it lets through. Each reply carries its tag back and is written into the on-chip storage slot with that index. The block then presents the stored replies to the master strictly in the order the requests were issued. The network transport itself is outside the block.

The number of slots is `2**TAG_W`. With the default of 8 slots, the block can reorder more replies than the four virtual channels a network would offer. One slot is one credit. A request is accepted only while a free credit exists. A credit comes back when its reply leaves the output stream.

Two small state machines control the block. The credit controller has the states `CR_OPEN` and `CR_FULL`:
- It moves from `CR_OPEN` to `CR_FULL` when an issue takes the last free slot and no release happens in the same cycle.
- It moves from `CR_FULL` back to `CR_OPEN` on any release.

The release sequencer has the states `REL_WAIT` and `REL_SHOW`:
- It moves from `REL_WAIT` to `REL_SHOW` once the oldest slot holds a reply. It loads that reply into the output register.
- In `REL_SHOW`, an accepted output frees the slot and advances the read pointer. If the following slot is already filled, the sequencer loads it and stays in `REL_SHOW`. Otherwise it returns to `REL_WAIT`.

Top module: `reply_reorder_buffer`

## Requirements
- R1: After reset, `req_ready` is 1, `out_valid` is 0 and `req_tag` is 0.
- R2: Tags are given out in ascending order, starting at 0 and wrapping modulo `2**TAG_W`. A tag is used by a request when `req_valid` and `req_ready` are both 1 at a clock edge.
- R3: At most `2**TAG_W` requests are outstanding at once. While that many requests are issued and not yet released, `req_ready` is 0.
- R4: Each output handshake frees one credit. `req_ready` returns to 1 in the cycle that follows a release from the full state.
- R5: Replies leave on `out_data` and `out_tag` in issue order, whatever order they arrive in. `out_tag` is the tag of the request, and `out_data` is the data received with that tag. `out_valid` stays 0 while the oldest outstanding reply is missing.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_tag` hold steady.
- R7: Some replies are dropped and never reach the output. This applies to a reply whose tag is not outstanding, to a reply that arrives in the same cycle as the issue of its tag, and to a second reply for a tag that is already filled. For a tag that is already filled, the first reply received is the one delivered.
- R8: Writing a reply into one slot and releasing a different slot in the same cycle both take effect.
- R9: When the following replies are already stored and `out_ready` stays 1, one reply is released in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Master wants to issue a request |
| req_ready | output | 1 | A credit is free; the request is issued at this edge |
| req_tag | output | TAG_W | Tag assigned to the request being issued |
| rsp_valid | input | 1 | A tagged reply is present |
| rsp_tag | input | TAG_W | Tag carried by the reply |
| rsp_data | input | DATA_W | Reply payload |
| out_valid | output | 1 | In-order reply available |
| out_ready | input | 1 | Downstream accepts the reply |
| out_data | output | DATA_W | Payload of the oldest outstanding reply |
| out_tag | output | TAG_W | Tag of the reply on `out_data` |

## Verification
The bench fills every slot and then returns the replies in fully reversed order. This shows whether the output waits for the oldest reply and then drains all slots back to back, as opposed to releasing replies in arrival order. It then sends two kinds of bad reply: a stray reply for a tag that was never issued, and a duplicate reply for a tag that is already filled. These show whether either kind is wrongly accepted. A directed case lands a reply for the next slot in the same cycle that the current slot is released, to expose any loss of a concurrent write. A long seeded random run then mixes random issue, random reply order, stray replies and output back-pressure. Each output is compared with the bench's own issue-order queue, and the credit count is compared every cycle.

// File: rtl/rob_tm_pkg.sv
package rob_tm_pkg;
    typedef enum logic {CR_OPEN, CR_FULL} credit_state_t;
    typedef enum logic {REL_WAIT, REL_SHOW} rel_state_t;
endpackage

// File: rtl/rob_credit_ctrl.sv
module rob_credit_ctrl
    import rob_tm_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_req,
    input  logic             release_en,
    output logic             issue_ready,
    output logic             issue_fire,
    output logic [TAG_W-1:0] issue_tag
);
    localparam int DEPTH = 1 << TAG_W;
    localparam int CNT_W = TAG_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_FREE = CNT_W'(DEPTH - 1);

    credit_state_t    state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [TAG_W-1:0] head_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CR_OPEN;
            count_q <= '0;
            head_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case ({issue_fire, release_en})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (issue_fire) head_q <= head_q + 1'b1;
        end
    end

    always_comb begin
        state_d     = state_q;
        issue_ready = 1'b0;
        unique case (state_q)
            CR_OPEN: begin
                issue_ready = 1'b1;
                if (issue_req && !release_en && count_q == LAST_FREE)
                    state_d = CR_FULL;
            end
            CR_FULL: begin
                if (release_en) state_d = CR_OPEN;
            end
            default: state_d = CR_OPEN;
        endcase
        issue_fire = issue_req && issue_ready;
        issue_tag  = head_q;
    end

    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CR_FULL) == (count_q == FULL_CNT)); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT); // R3
    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> head_q == $past(head_q) + 1'b1); // R2
    AST_RELEASE_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        release_en |-> count_q != '0); // R4
endmodule

// File: rtl/rob_slot_store.sv
module rob_slot_store #(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_en,
    input  logic [TAG_W-1:0]  issue_idx,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rel_en,
    input  logic [TAG_W-1:0]  rel_idx,
    input  logic [TAG_W-1:0]  rd0_idx,
    input  logic [TAG_W-1:0]  rd1_idx,
    output logic              rd0_valid,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd1_valid,
    output logic [DATA_W-1:0] rd1_data
);
    localparam int DEPTH = 1 << TAG_W;

    logic [DEPTH-1:0]  pend_q;
    logic [DEPTH-1:0]  full_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              wr_accept;

    assign wr_accept = wr_en && pend_q[wr_tag] && !full_q[wr_tag];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[s] <= 1'b0;
                full_q[s] <= 1'b0;
            end else if (rel_en && rel_idx == TAG_W'(s)) begin
                pend_q[s] <= 1'b0;
                full_q[s] <= 1'b0;
            end else begin
                if (issue_en && issue_idx == TAG_W'(s)) pend_q[s] <= 1'b1;
                if (wr_accept && wr_tag == TAG_W'(s))   full_q[s] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_accept) mem_q[wr_tag] <= wr_data;
    end

    assign rd0_valid = full_q[rd0_idx];
    assign rd0_data  = mem_q[rd0_idx];
    assign rd1_valid = full_q[rd1_idx];
    assign rd1_data  = mem_q[rd1_idx];

    AST_ISSUE_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> !pend_q[issue_idx]); // R3
    AST_REL_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |-> full_q[rel_idx] && pend_q[rel_idx]); // R5
    AST_FULL_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q & ~pend_q) == '0); // R7
    AST_FILL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept && !(rel_en && rel_idx == wr_tag) |=>
        full_q[$past(wr_tag)] && mem_q[$past(wr_tag)] == $past(wr_data)); // R8
endmodule

// File: rtl/rob_release_fsm.sv
module rob_release_fsm
    import rob_tm_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_valid,
    input  logic [DATA_W-1:0] cur_data,
    input  logic              nxt_valid,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag,
    output logic              rel_en
);
    rel_state_t        state_q, state_d;
    logic [TAG_W-1:0]  tail_q, tail_d;
    logic [DATA_W-1:0] data_q, data_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REL_WAIT;
            tail_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            tail_q  <= tail_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tail_d  = tail_q;
        data_d  = data_q;
        rel_en  = 1'b0;
        unique case (state_q)
            REL_WAIT: begin
                if (cur_valid) begin
                    data_d  = cur_data;
                    state_d = REL_SHOW;
                end
            end
            REL_SHOW: begin
                if (out_ready) begin
                    rel_en = 1'b1;
                    tail_d = tail_q + 1'b1;
                    if (nxt_valid) data_d  = nxt_data;
                    else           state_d = REL_WAIT;
                end
            end
            default: state_d = REL_WAIT;
        endcase
        out_valid = (state_q == REL_SHOW);
        out_data  = data_q;
        out_tag   = tail_q;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag)); // R6
    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |=> out_tag == $past(out_tag) + 1'b1); // R5
    AST_SHOW_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cur_valid); // R5
    AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && nxt_valid |=> out_valid); // R9
endmodule

// File: rtl/reply_reorder_buffer.sv
module reply_reorder_buffer
    import rob_tm_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag
);
    logic              issue_fire;
    logic              rel_en;
    logic [TAG_W-1:0]  nxt_idx;
    logic              cur_valid, nxt_valid;
    logic [DATA_W-1:0] cur_data, nxt_data;

    assign nxt_idx = out_tag + 1'b1;

    rob_credit_ctrl #(.TAG_W(TAG_W)) u_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_req   (req_valid),
        .release_en  (rel_en),
        .issue_ready (req_ready),
        .issue_fire  (issue_fire),
        .issue_tag   (req_tag)
    );

    rob_slot_store #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_en  (issue_fire),
        .issue_idx (req_tag),
        .wr_en     (rsp_valid),
        .wr_tag    (rsp_tag),
        .wr_data   (rsp_data),
        .rel_en    (rel_en),
        .rel_idx   (out_tag),
        .rd0_idx   (out_tag),
        .rd1_idx   (nxt_idx),
        .rd0_valid (cur_valid),
        .rd0_data  (cur_data),
        .rd1_valid (nxt_valid),
        .rd1_data  (nxt_data)
    );

    rob_release_fsm #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_release (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_valid (cur_valid),
        .cur_data  (cur_data),
        .nxt_valid (nxt_valid),
        .nxt_data  (nxt_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_tag   (out_tag),
        .rel_en    (rel_en)
    );
endmodule

// File: tb/tb_reply_reorder_buffer.sv
module tb_reply_reorder_buffer;
    localparam int TAG_W      = 3;
    localparam int DATA_W     = 16;
    localparam int DEPTH      = 1 << TAG_W;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid, req_ready;
    logic [TAG_W-1:0]  req_tag;
    logic              rsp_valid;
    logic [TAG_W-1:0]  rsp_tag;
    logic [DATA_W-1:0] rsp_data;
    logic              out_valid, out_ready;
    logic [DATA_W-1:0] out_data;
    logic [TAG_W-1:0]  out_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    reply_reorder_buffer #(.TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_tag(out_tag)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    bit                issued_m  [DEPTH];
    bit                replied_m [DEPTH];
    logic [DATA_W-1:0] data_m    [DEPTH];
    int                order_q [$];
    int                outstanding = 0;
    int                exp_head    = 0;

    bit                last_fire;
    logic [DATA_W-1:0] last_data;
    logic [TAG_W-1:0]  last_tag;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit credit_free(input int outs);
        return outs < DEPTH;
    endfunction

    task automatic tick();
        bit                f_req, f_out, hold;
        logic [DATA_W-1:0] h_data;
        logic [TAG_W-1:0]  h_tag;
        int                t;
        f_req  = req_valid && req_ready;
        f_out  = out_valid && out_ready;
        hold   = out_valid && !out_ready;
        h_data = out_data;
        h_tag  = out_tag;
        last_fire = f_out;
        last_data = out_data;
        last_tag  = out_tag;
        if (rsp_valid && issued_m[rsp_tag] && !replied_m[rsp_tag]) begin
            replied_m[rsp_tag] = 1'b1;
            data_m[rsp_tag]    = rsp_data;
        end
        if (f_out) begin
            t = order_q.pop_front();
            chk(int'(out_tag) == t, "R5 release order", 32'(out_tag), 32'(t));
            chk(replied_m[t] && out_data == data_m[t], "R5 release data", 32'(out_data), 32'(data_m[t]));
            issued_m[t]  = 1'b0;
            replied_m[t] = 1'b0;
            outstanding--;
        end
        if (f_req) begin
            chk(int'(req_tag) == exp_head, "R2 tag order", 32'(req_tag), 32'(exp_head));
            order_q.push_back(int'(req_tag));
            issued_m[req_tag] = 1'b1;
            exp_head = (exp_head + 1) % DEPTH;
            outstanding++;
        end
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(req_ready == credit_free(outstanding), "R4 credit ready", 32'(req_ready), 32'(credit_free(outstanding)));
        if (hold)
            chk(out_valid && out_data == h_data && out_tag == h_tag, "R6 hold under back-pressure",
                32'(out_data), 32'(h_data));
    endtask

    task automatic send(input int tag, input logic [DATA_W-1:0] d);
        rsp_valid = 1'b1;
        rsp_tag   = TAG_W'(tag);
        rsp_data  = d;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        int run;
        bit seen;
        req_valid = 0; rsp_valid = 0; rsp_tag = '0; rsp_data = '0; out_ready = 0;
        rst_n = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(out_valid == 1'b0, "R1 no output after reset", 32'(out_valid), 0);
        chk(req_tag == '0, "R1 first tag", 32'(req_tag), 0);

        // Fill every slot (R2, R3)
        req_valid = 1;
        repeat (DEPTH) tick();
        chk(req_ready == 1'b0, "R3 stall when all slots used", 32'(req_ready), 0);
        repeat (2) tick();
        chk(req_ready == 1'b0, "R3 still stalled", 32'(req_ready), 0);
        req_valid = 0;

        // Reverse-order replies (R5)
        for (int i = DEPTH - 1; i >= 1; i--) begin
            send(i, 16'hA000 + 16'(i));
            tick();
        end
        repeat (3) tick();
        chk(out_valid == 1'b0, "R5 waits for oldest reply", 32'(out_valid), 0);
        send(0, 16'hA000);
        tick();
        for (int i = 0; i < 4 && !out_valid; i++) tick();
        chk(out_valid == 1'b1, "R5 oldest reply shown", 32'(out_valid), 1);
        chk(out_tag == '0 && out_data == 16'hA000, "R5 oldest reply content", 32'(out_data), 32'hA000);

        // Back-pressure (R6) then back-to-back drain (R9, R4)
        out_ready = 0;
        repeat (3) tick();
        out_ready = 1;
        run = 0;
        for (int i = 0; i < DEPTH; i++) begin
            tick();
            if (last_fire) run++;
        end
        chk(run == DEPTH, "R9 one release per cycle", 32'(run), 32'(DEPTH));
        out_ready = 0;
        chk(out_valid == 1'b0 && outstanding == 0, "R5 all drained", 32'(out_valid), 0);

        // Stray and duplicate replies (R7)
        send(3, 16'hBAD0);
        tick();
        repeat (3) tick();
        chk(out_valid == 1'b0, "R7 stray reply dropped", 32'(out_valid), 0);
        req_valid = 1;
        send(0, 16'hBAD1);                   // same cycle as issue of tag 0: dropped
        repeat (4) tick();
        req_valid = 0;
        send(3, 16'h1111); tick();
        send(3, 16'h2222); tick();
        send(1, 16'h0101); tick();
        send(2, 16'h0202); tick();
        send(0, 16'h0000); tick();
        out_ready = 1;
        seen = 0;
        for (int i = 0; i < 12 && outstanding > 0; i++) begin
            tick();
            if (last_fire && last_tag == 3'd3) begin
                seen = 1;
                chk(last_data == 16'h1111, "R7 first reply kept", 32'(last_data), 32'h1111);
            end
            if (last_fire && last_tag == 3'd0)
                chk(last_data == 16'h0000, "R7 reply during issue dropped", 32'(last_data), 0);
        end
        chk(seen, "R7 tag 3 released", 32'(seen), 1);
        out_ready = 0;

        // Write and release of different slots in one cycle (R8)
        req_valid = 1;
        repeat (2) tick();
        req_valid = 0;
        send(4, 16'h4444); tick();
        for (int i = 0; i < 4 && !out_valid; i++) tick();
        out_ready = 1;
        send(5, 16'h5555);
        tick();
        seen = 0;
        for (int i = 0; i < 6 && !seen; i++) begin
            tick();
            if (last_fire && last_tag == 3'd5) begin
                seen = 1;
                chk(last_data == 16'h5555, "R8 concurrent write kept", 32'(last_data), 32'h5555);
            end
        end
        chk(seen, "R8 concurrent slot released", 32'(seen), 1);

        // Seeded random mix
        for (int c = 0; c < 4000; c++) begin
            int t;
            req_valid = ($urandom % 2) == 0;
            out_ready = ($urandom % 4) != 0;
            t = int'($urandom % DEPTH);
            if (($urandom % 10) == 0 || (issued_m[t] && !replied_m[t] && ($urandom % 2) == 0))
                send(t, 16'($urandom));
            tick();
        end

        // Drain
        req_valid = 0;
        out_ready = 1;
        for (int c = 0; c < 300 && outstanding > 0; c++) begin
            for (int t = 0; t < DEPTH; t++)
                if (!rsp_valid && issued_m[t] && !replied_m[t]) send(t, 16'($urandom));
            tick();
        end
        repeat (4) tick();
        chk(outstanding == 0 && out_valid == 1'b0, "R5 final drain", 32'(outstanding), 0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end
endmodule